// File: doc/BRIEF.md
# Eight-bit compare-match timer with pin control

This block is an 8-bit up-counter with two compare registers, called channel A and channel B, and one combined control and status register. Every cycle in which the count-enable input is high, the counter advances by one. A channel matches when such a step makes the counter equal to that channel's compare value. Each match sets a sticky flag. A step from 0xFF to 0x00 sets an overflow flag.

The timer output pin reacts to each match. The reaction is chosen per channel by a two-bit action code. When both channels match in the same cycle, channel B takes priority. A control bit turns matches on channel A into a one-cycle start request for an A/D converter.

Software reaches all four registers through a small register bus. The read path is combinational. A read strobe marks a status read. A flag is cleared by first reading it as 1 and then writing 0 to it.

Top module: `cmp_timer8`

## Requirements
- R1: The counter advances by one on each cycle with `cnt_en` high. It holds when `cnt_en` is low. A bus write to address 0 loads the counter and takes precedence over a step in the same cycle. Address 1 holds compare A and address 2 holds compare B. Both reset to 0xFF.
- R2: A step from 0xFF to 0x00 sets the overflow flag, which is bit 5 of the status register at address 3. A bus load of the counter never sets it.
- R3: A flag in bits 7..5 of address 3 is cleared only by a write with a 0 in that bit. That write must follow a read strobe (`bus_rd`) at address 3 made while the flag was 1, with no other write to address 3 in between. Writing 1 leaves the flag as it is. Writing 0 without that prior read leaves the flag as it is. Any write to address 3 cancels earlier reads.
- R4: If a flag's set event and a valid clearing write occur in the same cycle, the flag reads 1 afterwards.
- R5: A step that makes the counter equal compare A sets bit 6 of address 3. A step that makes it equal compare B sets bit 7. A compare value written in the same cycle is used only from the next cycle on.
- R6: Bits 1:0 of address 3 give the pin action on a match A. Bits 3:2 give the pin action on a match B. The codes are 00 no change, 01 drive low, 10 drive high and 11 invert. The pin changes in the cycle after the matching step's clock edge.
- R7: When both channels match in the same step, the B action is applied if it is not 00. Otherwise the A action is applied.
- R8: While bits 3:0 of address 3 are all 0, `tmr_out` is 0. The internal pin level is kept and shows again once any select bit is set.
- R9: After reset the counter is 0, both compares are 0xFF, address 3 reads 0x00, and `tmr_out` and `adc_trig` are 0. The pin stays 0 until the first match with an action.
- R10: With bit 4 of address 3 set, each match A gives a pulse of exactly one cycle on `adc_trig`, aligned with the flag update. With bit 4 clear, no pulse is made. A match B alone never makes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count step enable |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare A, 2 compare B, 3 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing on address 3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| tmr_out | output | 1 | Timer output pin |
| adc_trig | output | 1 | A/D start request pulse |

## Verification
Directed sequences use several kinds of input. Counter loads next to enabled and idle cycles separate stepping from loading. Each of the four action codes is driven on both channels, with compare values equal and then apart, to check the per-channel decoding and the B-over-A priority. Flag clears are tried with a write of 1, with a write of 0 without a prior read, and with a write of 0 after a read, and a clearing write is placed on the very cycle of a match, so that a missing read check or a wrong set/clear priority shows up. A seeded random phase then mixes bus traffic with counting and compares every read, pin level and trigger pulse against a bench model.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } pin_act_e;

  localparam logic [1:0] REG_COUNT = 2'd0;
  localparam logic [1:0] REG_CMPA  = 2'd1;
  localparam logic [1:0] REG_CMPB  = 2'd2;
  localparam logic [1:0] REG_CSR   = 2'd3;

  localparam int NUM_FLAGS = 3;   // index 0 overflow, 1 match A, 2 match B
  localparam int FLAG_LSB  = 5;   // flags live in csr bits 7..5
  localparam int CTRL_W    = 5;   // csr bits 4..0
  localparam int TRIG_BIT  = 4;

  // Next pin level for one action code.
  function automatic logic act_apply(input pin_act_e act, input logic cur);
    logic r;
    unique case (act)
      ACT_KEEP: r = cur;
      ACT_LOW:  r = 1'b0;
      ACT_HIGH: r = 1'b1;
      default:  r = ~cur;
    endcase
    return r;
  endfunction

  // Pin is driven only when some select bit is non-zero.
  function automatic logic pin_enabled(input logic [3:0] sel);
    return |sel;
  endfunction

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         step;
  logic [W-1:0] next_val;

  assign step     = step_en && !load;
  assign next_val = count + ONE;
  assign hit_a    = step && (next_val == cmp_a);
  assign hit_b    = step && (next_val == cmp_b);
  assign wrap     = step && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= next_val;
  end
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         csr_rd,
  input  logic         csr_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic armed;
    always_ff @(posedge clk) begin
      if (!rst_n)                   armed <= 1'b0;
      else if (csr_wr)              armed <= 1'b0;
      else if (csr_rd && flags[i])  armed <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                              flags[i] <= 1'b0;
      else if (set_evt[i])                     flags[i] <= 1'b1;
      else if (csr_wr && armed && !wbits[i])   flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr8_pin.sv
module tmr8_pin
  import tmr8_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_a,
  input  logic     hit_b,
  input  pin_act_e act_a,
  input  pin_act_e act_b,
  input  logic     trig_en,
  output logic     level,
  output logic     pin,
  output logic     trig
);
  logic level_nxt;

  always_comb begin
    if (hit_b && act_b != ACT_KEEP) level_nxt = act_apply(act_b, level);
    else if (hit_a)                 level_nxt = act_apply(act_a, level);
    else                            level_nxt = level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      trig  <= 1'b0;
    end else begin
      level <= level_nxt;
      trig  <= hit_a && trig_en;
    end
  end

  assign pin = level && pin_enabled({act_b, act_a});
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         tmr_out,
  output logic         adc_trig
);
  logic [W-1:0]         count_q, cmp_a_q, cmp_b_q;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_FLAGS-1:0] flags;
  logic                 cnt_load, csr_wr, csr_rd;
  logic                 hit_a, hit_b, wrap, lvl;

  assign cnt_load = bus_wr && bus_addr == REG_COUNT;
  assign csr_wr   = bus_wr && bus_addr == REG_CSR;
  assign csr_rd   = bus_rd && bus_addr == REG_CSR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a_q <= '1;
      cmp_b_q <= '1;
      ctrl_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == REG_CMPA) cmp_a_q <= bus_wdata;
      if (bus_addr == REG_CMPB) cmp_b_q <= bus_wdata;
      if (bus_addr == REG_CSR)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
    end
  end

  tmr8_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .step_en(cnt_en), .load(cnt_load),
    .load_val(bus_wdata), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q),
    .count(count_q), .hit_a(hit_a), .hit_b(hit_b), .wrap(wrap)
  );

  tmr8_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt({hit_b, hit_a, wrap}),
    .csr_rd(csr_rd), .csr_wr(csr_wr),
    .wbits(bus_wdata[FLAG_LSB +: NUM_FLAGS]), .flags(flags)
  );

  tmr8_pin u_pin (
    .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
    .act_a(pin_act_e'(ctrl_q[1:0])), .act_b(pin_act_e'(ctrl_q[3:2])),
    .trig_en(ctrl_q[TRIG_BIT]), .level(lvl), .pin(tmr_out), .trig(adc_trig)
  );

  always_comb begin
    unique case (bus_addr)
      REG_COUNT: bus_rdata = count_q;
      REG_CMPA:  bus_rdata = cmp_a_q;
      REG_CMPB:  bus_rdata = cmp_b_q;
      default:   bus_rdata = W'({flags, ctrl_q});
    endcase
  end
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         cnt_load,
  input logic [W-1:0] count,
  input logic         hit_a,
  input logic         hit_b,
  input logic         wrap,
  input logic [2:0]   flags,
  input logic         csr_wr,
  input logic [W-1:0] wdata,
  input logic         level,
  input logic         trig,
  input logic         trig_en
);
  // R1: an enabled step without a load advances by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_load) |=> (count == W'($past(count) + W'(1))));

  // R2: a wrap event sets the overflow flag
  a_r2_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[0]);

  // R3: the overflow flag only falls after a write of 0 to its bit
  a_r3_ovf_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(csr_wr && !wdata[5]));

  // R4 / R5: a match always leaves its flag set
  a_r4_match_a_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flags[1]);
  a_r5_match_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> flags[2]);

  // R6: the pin level moves only on a match
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a || hit_b) |=> $stable(level));

  // R10: a trigger pulse comes only from an enabled match A
  a_r10_trig_source: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(hit_a && trig_en));
endmodule

bind cmp_timer8 tmr8_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_load(cnt_load),
  .count(count_q), .hit_a(hit_a), .hit_b(hit_b), .wrap(wrap),
  .flags(flags), .csr_wr(csr_wr), .wdata(bus_wdata), .level(lvl),
  .trig(adc_trig), .trig_en(ctrl_q[4])
);

// File: tb/test_cmp_timer8.sv
module test_cmp_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_out, adc_trig;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmp_timer8 i_cmp_timer8 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_out(tmr_out), .adc_trig(adc_trig)
  );

  // bench model
  logic [7:0] m_cnt, m_ca, m_cb;
  logic [4:0] m_ctl;
  logic [2:0] m_flag, m_arm;
  logic       m_lvl, m_trig;

  function automatic logic act_model(input logic [1:0] code, input logic cur);
    if (code == 2'b00) return cur;
    if (code == 2'b11) return !cur;
    return code[1];
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_ca;
      2'd2: return m_cb;
      default: return {m_flag, m_ctl};
    endcase
  endfunction

  function automatic logic exp_pin();
    return m_lvl & (m_ctl[3:0] != 4'd0);
  endfunction

  task automatic model_reset();
    m_cnt = 8'h00; m_ca = 8'hFF; m_cb = 8'hFF; m_ctl = 5'd0;
    m_flag = 3'd0; m_arm = 3'd0; m_lvl = 1'b0; m_trig = 1'b0;
  endtask

  task automatic model_edge(input logic en, input logic wr, input logic rd,
                            input logic [1:0] a, input logic [7:0] wd);
    logic step, ha, hb, wp;
    logic [7:0] nx;
    logic [2:0] ev, nf, na;
    step = en && !(wr && a == 2'd0);
    nx = m_cnt + 8'd1;
    ha = step && (nx == m_ca);
    hb = step && (nx == m_cb);
    wp = step && (m_cnt == 8'hFF);
    ev = {hb, ha, wp};
    for (int i = 0; i < 3; i++) begin
      nf[i] = ev[i] | (m_flag[i] & !(wr && a == 2'd3 && m_arm[i] && !wd[5+i]));
      na[i] = (wr && a == 2'd3) ? 1'b0 : (m_arm[i] | (rd && a == 2'd3 && m_flag[i]));
    end
    if (hb && m_ctl[3:2] != 2'b00) m_lvl = act_model(m_ctl[3:2], m_lvl);
    else if (ha)                  m_lvl = act_model(m_ctl[1:0], m_lvl);
    m_trig = ha & m_ctl[4];
    m_flag = nf; m_arm = na;
    if (wr && a == 2'd0) m_cnt = wd;
    else if (step)       m_cnt = nx;
    if (wr && a == 2'd1) m_ca = wd;
    if (wr && a == 2'd2) m_cb = wd;
    if (wr && a == 2'd3) m_ctl = wd[4:0];
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic en, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [7:0] wd,
                     output logic [7:0] rd_val);
    cnt_en = en; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    #1 rd_val = bus_rdata;
    @(posedge clk);
    model_edge(en, wr, rd, a, wd);
    @(negedge clk);
    check("R6 pin", {7'd0, tmr_out}, {7'd0, exp_pin()});
    check("R10 trig", {7'd0, adc_trig}, {7'd0, m_trig});
    cnt_en = 0; bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] wd);
    logic [7:0] v;
    cyc(1'b0, 1'b1, 1'b0, a, wd, v);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    cyc(1'b0, 1'b0, 1'b1, a, 8'd0, v);
  endtask

  task automatic steps(input int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 out", {6'd0, tmr_out, adc_trig}, 8'h00);
    rd_reg(2'd0, v); check("R9 count", v, 8'h00);
    rd_reg(2'd1, v); check("R9 cmpA", v, 8'hFF);
    rd_reg(2'd2, v); check("R9 cmpB", v, 8'hFF);
    rd_reg(2'd3, v); check("R9 csr", v, 8'h00);

    // R1 load, step, hold
    wr_reg(2'd0, 8'h10); steps(3);
    rd_reg(2'd0, v); check("R1 step", v, 8'h13);
    rd_reg(2'd0, v); check("R1 hold", v, 8'h13);
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 8'h40, v);
    rd_reg(2'd0, v); check("R1 load wins", v, 8'h40);

    // R2 overflow
    wr_reg(2'd0, 8'hFE); steps(1);
    rd_reg(2'd3, v); check("R2 no early ovf", v & 8'h20, 8'h00);
    steps(1);
    rd_reg(2'd3, v); check("R2 ovf set", v & 8'h20, 8'h20);

    // R3 clearing handshake (flag was just read as 1)
    wr_reg(2'd3, 8'hE0);
    rd_reg(2'd0, v);
    wr_reg(2'd3, 8'h00);
    cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'd0, v); check("R3 no clear w/o read", v & 8'h20, 8'h20);
    rd_reg(2'd3, v);
    wr_reg(2'd3, 8'h00);
    cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'd0, v); check("R3 cleared", v & 8'h20, 8'h00);

    // R5 match flags, R4 set wins
    wr_reg(2'd1, 8'h20); wr_reg(2'd0, 8'h1E); steps(1);
    rd_reg(2'd3, v); check("R5 no early A", v & 8'h40, 8'h00);
    steps(1);
    rd_reg(2'd3, v); check("R5 match A flag", v & 8'h40, 8'h40);
    wr_reg(2'd0, 8'h1F);
    rd_reg(2'd3, v);
    cyc(1'b1, 1'b1, 1'b0, 2'd3, 8'h00, v);
    rd_reg(2'd3, v); check("R4 set wins", v & 8'h40, 8'h40);
    wr_reg(2'd2, 8'h30); wr_reg(2'd0, 8'h2F); steps(1);
    rd_reg(2'd3, v); check("R5 match B flag", v & 8'h80, 8'h80);

    // R6 actions on A (B keeps)
    wr_reg(2'd1, 8'h40); wr_reg(2'd2, 8'h90);
    wr_reg(2'd3, 8'h02); wr_reg(2'd0, 8'h3F); steps(1);
    check("R6 A high", {7'd0, tmr_out}, 8'h01);
    wr_reg(2'd3, 8'h01); wr_reg(2'd0, 8'h3F); steps(1);
    check("R6 A low", {7'd0, tmr_out}, 8'h00);
    wr_reg(2'd3, 8'h03); wr_reg(2'd0, 8'h3F); steps(1);
    check("R6 A flip", {7'd0, tmr_out}, 8'h01);
    wr_reg(2'd3, 8'h04); wr_reg(2'd0, 8'h3F); steps(1);
    check("R6 A keep", {7'd0, tmr_out}, 8'h01);
    wr_reg(2'd3, 8'h0C); wr_reg(2'd0, 8'h8F); steps(1);
    check("R6 B flip", {7'd0, tmr_out}, 8'h00);

    // R7 priority with equal compares
    wr_reg(2'd2, 8'h40);
    wr_reg(2'd3, 8'h06); wr_reg(2'd0, 8'h3F); steps(1);
    check("R7 B low over A high", {7'd0, tmr_out}, 8'h00);
    wr_reg(2'd3, 8'h03); wr_reg(2'd0, 8'h3F); steps(1);
    check("R7 B keep lets A flip", {7'd0, tmr_out}, 8'h01);

    // R8 disabled output keeps level
    wr_reg(2'd3, 8'h00);
    check("R8 disabled", {7'd0, tmr_out}, 8'h00);
    wr_reg(2'd3, 8'h04);
    check("R8 reenabled", {7'd0, tmr_out}, 8'h01);

    // R10 trigger pulse
    wr_reg(2'd2, 8'h90);
    wr_reg(2'd3, 8'h10); wr_reg(2'd0, 8'h3F); steps(1);
    check("R10 pulse", {7'd0, adc_trig}, 8'h01);
    steps(1);
    check("R10 one cycle", {7'd0, adc_trig}, 8'h00);
    wr_reg(2'd3, 8'h00); wr_reg(2'd0, 8'h3F); steps(1);
    check("R10 disabled", {7'd0, adc_trig}, 8'h00);
    wr_reg(2'd3, 8'h10); wr_reg(2'd0, 8'h8F); steps(1);
    check("R10 B no pulse", {7'd0, adc_trig}, 8'h00);

    // random phase
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4000; i++) begin
      logic en, wr, rd;
      logic [1:0] a;
      logic [7:0] wd, exp_v;
      en = ($urandom % 10) < 7;
      wr = ($urandom % 10) < 2;
      rd = ($urandom % 10) < 3;
      a  = 2'($urandom % 4);
      wd = 8'($urandom);
      if (a == 2'd0 && ($urandom % 2) == 0) wd = m_cnt + 8'd1;
      exp_v = exp_read(a);
      cyc(en, wr, rd, a, wd, v);
      check(a == 2'd3 ? "R3 csr read" : "R1 reg read", v, exp_v);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule